// File: doc/BRIEF.md
# EPP Address/Data Cycle Controller

This block runs enhanced parallel port address and data transfers between a host I/O bus and an attached peripheral. The host picks one of two port registers (address or data), sets a direction bit, and pulls its read or write strobe low. The controller then prepares the peripheral side: it sets the write-direction line and the data bus drivers, and it drives the active-low address or data strobe. It holds host ready low for as long as the peripheral asks it to wait. When the host lets go of its strobe, the peripheral strobe ends.

The peripheral wait input passes through a two-flop synchronizer. A counter limits how long a stalled peripheral can hold the host. When that limit runs out, host ready is released and a sticky time-out flag is set; a write-one pulse clears the flag. In a read, the byte returned to the host is captured from the peripheral bus on the edge where the synchronized wait is first seen released, or where the time-out fires. The peripheral bus is modelled as separate input, output and output-enable signals.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset both peripheral strobes are high, per_write_n is high, per_d_oe is 0, host_rdy is 1, tmo_flag is 0 and host_rdata is 0.
- R2: A cycle starts only when exactly one of host_sel_addr and host_sel_data is 1, together with either host_wr_n low and host_dir 0 (write) or host_rd_n low and host_dir 1 (read). Any other combination is ignored: the strobes stay high, host_rdy stays 1, and per_write_n and per_d_oe keep their values.
- R3: Write: on the first edge that sees the request, per_write_n goes low, per_d_oe goes high and per_d_o takes host_wdata. The strobe stays high on that edge and goes low on the next edge.
- R4: Read: on the first edge, per_write_n goes high and per_d_oe goes low. The strobe goes low only on the next edge, so it is never low while a read has the bus driven.
- R5: Selecting the address register drives per_astb_n low. Selecting the data register drives per_dstb_n low. The other strobe stays high, and the two are never low together.
- R6: host_rdy falls on the first edge of a cycle. It rises on the third edge after per_wait_n returns high, which is two synchronizer edges plus one. If wait is already high when the strobe falls, it rises on the first edge with the strobe low.
- R7: If synchronized wait stays low, host_rdy is released on the TMO_CYCLES-th edge counted from the edge after the strobe fell, and tmo_flag is set on the same edge.
- R8: tmo_flag stays set across later cycles until stat_clr is pulsed high; a time-out on the same edge as the clear wins.
- R9: In a read, host_rdata takes per_d_i on the edge where host_rdy rises. It then holds that value while host_rd_n stays low, even if per_d_i changes.
- R10: The edge after the host's active strobe returns high ends the cycle in any phase: the peripheral strobe goes high and host_rdy returns to 1.
- R11: After a cycle ends, per_write_n, per_d_oe and per_d_o keep their values until the next cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_addr | input | 1 | Host selects the address register |
| host_sel_data | input | 1 | Host selects the data register |
| host_dir | input | 1 | Direction bit: 1 read, 0 write |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DW | Byte from the host |
| host_rdata | output | DW | Byte captured for the host |
| host_rdy | output | 1 | Host ready, low stretches the host cycle |
| stat_clr | input | 1 | Write-one pulse that clears tmo_flag |
| tmo_flag | output | 1 | Sticky time-out status |
| per_d_i | input | DW | Peripheral data bus, input side |
| per_d_o | output | DW | Peripheral data bus, output side |
| per_d_oe | output | 1 | Peripheral bus output enable |
| per_write_n | output | 1 | Write-direction line, low for writes |
| per_astb_n | output | 1 | Address strobe, active low |
| per_dstb_n | output | 1 | Data strobe, active low |
| per_wait_n | input | 1 | Peripheral wait, active low, asynchronous |

## Verification
The bench builds the controller with DW at 8 and TMO_CYCLES lowered from its 500-cycle default to 20. This lets a full time-out, including the exact edge where ready is released, run within a few dozen clocks. It can then be followed by the clear of the sticky flag. The short limit also leaves wide room for the three-edge synchronizer delay, so a wait release is never mistaken for a time-out.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_STRB  = 2'd2,
        ST_HOLD  = 2'd3
    } epp_state_e;

    typedef struct packed {
        epp_state_e st;
        logic       rdy;
        logic       write_n;
        logic       oe;
        logic       astb_n;
        logic       dstb_n;
        logic       use_addr;
        logic       is_rd;
        logic       tmo;
    } epp_ctl_s;

endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_in;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_out = s2_q;
endmodule

// File: rtl/epp_tmo_cnt.sv
module epp_tmo_cnt #(
    parameter int LIMIT = 500,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + 1'b1 : '0;
        expired = run && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
    import epp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int TMO_CYCLES = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel_addr,
    input  logic          host_sel_data,
    input  logic          host_dir,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    input  logic          stat_clr,
    output logic          tmo_flag,
    input  logic [DW-1:0] per_d_i,
    output logic [DW-1:0] per_d_o,
    output logic          per_d_oe,
    output logic          per_write_n,
    output logic          per_astb_n,
    output logic          per_dstb_n,
    input  logic          per_wait_n
);
    localparam int CW = $clog2(TMO_CYCLES + 1);

    epp_ctl_s      c_d, c_q;
    logic [DW-1:0] rdata_d, rdata_q;
    logic [DW-1:0] pdo_d, pdo_q;
    logic          wait_ok;
    logic          expired;
    logic          wr_req, rd_req, sel_ok, hs_end;

    epp_wait_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (per_wait_n),
        .sync_out (wait_ok)
    );

    epp_tmo_cnt #(.LIMIT(TMO_CYCLES), .CW(CW)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (c_q.st == ST_STRB),
        .expired (expired)
    );

    always_comb begin
        sel_ok  = host_sel_addr ^ host_sel_data;
        wr_req  = !host_wr_n && !host_dir;
        rd_req  = !host_rd_n && host_dir;
        hs_end  = c_q.is_rd ? host_rd_n : host_wr_n;

        c_d     = c_q;
        rdata_d = rdata_q;
        pdo_d   = pdo_q;

        if (stat_clr) c_d.tmo = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (sel_ok && (wr_req || rd_req)) begin
                    c_d.st       = ST_SETUP;
                    c_d.rdy      = 1'b0;
                    c_d.is_rd    = rd_req;
                    c_d.use_addr = host_sel_addr;
                    c_d.write_n  = rd_req;
                    c_d.oe       = !rd_req;
                    if (!rd_req) pdo_d = host_wdata;
                end
            end
            ST_SETUP: begin
                if (hs_end) begin
                    c_d.st  = ST_IDLE;
                    c_d.rdy = 1'b1;
                end else begin
                    c_d.st     = ST_STRB;
                    c_d.astb_n = !c_q.use_addr;
                    c_d.dstb_n = c_q.use_addr;
                end
            end
            ST_STRB: begin
                if (hs_end) begin
                    c_d.st     = ST_IDLE;
                    c_d.rdy    = 1'b1;
                    c_d.astb_n = 1'b1;
                    c_d.dstb_n = 1'b1;
                end else if (wait_ok || expired) begin
                    c_d.st  = ST_HOLD;
                    c_d.rdy = 1'b1;
                    if (!wait_ok) c_d.tmo = 1'b1;
                    if (c_q.is_rd) rdata_d = per_d_i;
                end
            end
            ST_HOLD: begin
                if (hs_end) begin
                    c_d.st     = ST_IDLE;
                    c_d.astb_n = 1'b1;
                    c_d.dstb_n = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st       <= ST_IDLE;
            c_q.rdy      <= 1'b1;
            c_q.write_n  <= 1'b1;
            c_q.oe       <= 1'b0;
            c_q.astb_n   <= 1'b1;
            c_q.dstb_n   <= 1'b1;
            c_q.use_addr <= 1'b0;
            c_q.is_rd    <= 1'b0;
            c_q.tmo      <= 1'b0;
            rdata_q      <= '0;
            pdo_q        <= '0;
        end else begin
            c_q     <= c_d;
            rdata_q <= rdata_d;
            pdo_q   <= pdo_d;
        end
    end

    assign host_rdata  = rdata_q;
    assign host_rdy    = c_q.rdy;
    assign tmo_flag    = c_q.tmo;
    assign per_d_o     = pdo_q;
    assign per_d_oe    = c_q.oe;
    assign per_write_n = c_q.write_n;
    assign per_astb_n  = c_q.astb_n;
    assign per_dstb_n  = c_q.dstb_n;
endmodule

// File: rtl/epp_cycle_chk.sv
module epp_cycle_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_rd_n,
    input logic          host_wr_n,
    input logic          host_rdy,
    input logic [DW-1:0] host_rdata,
    input logic          stat_clr,
    input logic          tmo_flag,
    input logic          per_d_oe,
    input logic          per_write_n,
    input logic          per_astb_n,
    input logic          per_dstb_n
);
    logic strb_low;
    assign strb_low = !per_astb_n || !per_dstb_n;

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!per_astb_n && !per_dstb_n));

    // R4
    read_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_low && per_write_n) |-> !per_d_oe);

    // R3
    setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_low && !$past(strb_low)) |-> ($stable(per_write_n) && $stable(per_d_oe)));

    // R6
    ready_drop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rdy) |-> !strb_low);

    // R7
    tmo_releases_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> host_rdy);

    // R8
    tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !stat_clr) |=> tmo_flag);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdy && strb_low && per_write_n && !host_rd_n) |=> $stable(host_rdata));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_n && host_wr_n) |=> !strb_low);
endmodule

bind epp_cycle_ctrl epp_cycle_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .host_rdy    (host_rdy),
    .host_rdata  (host_rdata),
    .stat_clr    (stat_clr),
    .tmo_flag    (tmo_flag),
    .per_d_oe    (per_d_oe),
    .per_write_n (per_write_n),
    .per_astb_n  (per_astb_n),
    .per_dstb_n  (per_dstb_n)
);

// File: tb/epp_cycle_ctrl_test.sv
module epp_cycle_ctrl_test;
    localparam int DW  = 8;
    localparam int TMO = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel_addr = 1'b0, host_sel_data = 1'b0, host_dir = 1'b0;
    logic          host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_rdy, stat_clr = 1'b0, tmo_flag;
    logic [DW-1:0] per_d_i = '0;
    logic [DW-1:0] per_d_o;
    logic          per_d_oe, per_write_n, per_astb_n, per_dstb_n;
    logic          per_wait_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    epp_cycle_ctrl #(.DW(DW), .TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel_addr(host_sel_addr), .host_sel_data(host_sel_data),
        .host_dir(host_dir), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
        .stat_clr(stat_clr), .tmo_flag(tmo_flag),
        .per_d_i(per_d_i), .per_d_o(per_d_o), .per_d_oe(per_d_oe),
        .per_write_n(per_write_n), .per_astb_n(per_astb_n),
        .per_dstb_n(per_dstb_n), .per_wait_n(per_wait_n)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_idle();
        host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_sel_addr = 1'b0; host_sel_data = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "astb_n", per_astb_n, 1);
        check("R1", "dstb_n", per_dstb_n, 1);
        check("R1", "write_n", per_write_n, 1);
        check("R1", "oe", per_d_oe, 0);
        check("R1", "rdy", host_rdy, 1);
        check("R1", "tmo", tmo_flag, 0);
        check("R1", "rdata", host_rdata, 0);
    endtask

    task automatic t_write_data();
        host_dir = 1'b0; host_sel_data = 1'b1; host_wdata = 8'h5A; host_wr_n = 1'b0;
        ticks(1);
        check("R3", "write_n setup", per_write_n, 0);
        check("R3", "oe setup", per_d_oe, 1);
        check("R3", "data setup", per_d_o, 8'h5A);
        check("R3", "strobe high in setup", per_dstb_n, 1);
        check("R6", "rdy low in setup", host_rdy, 0);
        ticks(1);
        check("R5", "dstb low", per_dstb_n, 0);
        check("R5", "astb high", per_astb_n, 1);
        ticks(1);
        check("R6", "rdy with wait high", host_rdy, 1);
        host_wdata = 8'h00;
        host_wr_n = 1'b1;
        ticks(1);
        check("R10", "dstb end", per_dstb_n, 1);
        check("R11", "oe held", per_d_oe, 1);
        check("R11", "data held", per_d_o, 8'h5A);
        check("R11", "write_n held", per_write_n, 0);
        host_idle();
        ticks(2);
    endtask

    task automatic t_ignored();
        host_dir = 1'b1; host_sel_data = 1'b1; host_wr_n = 1'b0;
        ticks(4);
        check("R2", "dir mismatch strobe", per_dstb_n, 1);
        check("R2", "dir mismatch rdy", host_rdy, 1);
        check("R2", "dir mismatch write_n", per_write_n, 0);
        host_idle();
        host_dir = 1'b0; host_sel_addr = 1'b1; host_sel_data = 1'b1; host_wr_n = 1'b0;
        ticks(4);
        check("R2", "double select astb", per_astb_n, 1);
        check("R2", "double select dstb", per_dstb_n, 1);
        check("R2", "double select oe", per_d_oe, 1);
        host_idle();
        ticks(2);
    endtask

    task automatic t_read_wait();
        per_wait_n = 1'b0; per_d_i = 8'hA5;
        ticks(3);
        host_dir = 1'b1; host_sel_addr = 1'b1; host_rd_n = 1'b0;
        ticks(1);
        check("R4", "write_n high", per_write_n, 1);
        check("R4", "oe low", per_d_oe, 0);
        check("R4", "astb high in setup", per_astb_n, 1);
        ticks(1);
        check("R5", "astb low", per_astb_n, 0);
        check("R5", "dstb high", per_dstb_n, 1);
        per_wait_n = 1'b1;
        ticks(2);
        check("R6", "rdy low during sync", host_rdy, 0);
        ticks(1);
        check("R6", "rdy after sync", host_rdy, 1);
        check("R9", "captured", host_rdata, 8'hA5);
        per_d_i = 8'h3C;
        ticks(2);
        check("R9", "held", host_rdata, 8'hA5);
        check("R7", "no timeout", tmo_flag, 0);
        host_rd_n = 1'b1;
        ticks(1);
        check("R10", "astb end", per_astb_n, 1);
        host_idle();
        ticks(2);
    endtask

    task automatic t_timeout();
        per_wait_n = 1'b0; per_d_i = 8'h77;
        ticks(3);
        host_dir = 1'b1; host_sel_data = 1'b1; host_rd_n = 1'b0;
        ticks(1 + TMO);
        check("R7", "rdy before limit", host_rdy, 0);
        check("R7", "flag before limit", tmo_flag, 0);
        ticks(1);
        check("R7", "rdy at limit", host_rdy, 1);
        check("R7", "flag at limit", tmo_flag, 1);
        check("R9", "timeout capture", host_rdata, 8'h77);
        check("R7", "strobe still low", per_dstb_n, 0);
        host_rd_n = 1'b1;
        ticks(1);
        check("R10", "dstb end after timeout", per_dstb_n, 1);
        host_idle();
        per_wait_n = 1'b1;
        ticks(3);
        check("R8", "flag sticky", tmo_flag, 1);
        stat_clr = 1'b1;
        ticks(1);
        stat_clr = 1'b0;
        check("R8", "flag cleared", tmo_flag, 0);
    endtask

    task automatic t_early_end();
        per_wait_n = 1'b0;
        ticks(3);
        host_dir = 1'b0; host_sel_addr = 1'b1; host_wdata = 8'hC3; host_wr_n = 1'b0;
        ticks(2);
        check("R5", "astb low write", per_astb_n, 0);
        check("R6", "rdy held by wait", host_rdy, 0);
        host_wr_n = 1'b1;
        ticks(1);
        check("R10", "early end astb", per_astb_n, 1);
        check("R10", "early end rdy", host_rdy, 1);
        check("R11", "data after early end", per_d_o, 8'hC3);
        host_idle();
        per_wait_n = 1'b1;
        ticks(3);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        t_reset();
        t_write_data();
        t_ignored();
        t_read_wait();
        t_timeout();
        t_early_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule